// File: doc/BRIEF.md
# Bit Search Unit

This block finds the position of a chosen bit pattern in a 32-bit word, scanning from the most significant bit. Software writes a word to one of three search addresses. The address picks what counts as a match: the first bit that is set, the first bit that is clear, or the first bit whose value differs from the top bit of the word.

The write stores the word and captures the search result in the same clock edge. A valid pulse marks the cycle in which the new result is first readable. Positions count from 0 at the MSB up to 31 at the LSB. The value 32 means that nothing matched.

The read port is combinational over the stored state. A fourth address reads back the last word that was searched. Any of the three search addresses reads the current result.

Top module: `bit_seek`

## Requirements
- R1: A write to address 0 (find-one) stores a result equal to the index of the first 1 bit, counting the MSB (bit 31) as index 0 and bit 0 as index 31.
- R2: A write to address 1 (find-zero) stores a result equal to the index of the first 0 bit, with the same index numbering as R1.
- R3: A write to address 2 (find-change) stores the index of the first bit, scanning from bit 30 down to bit 0, whose value differs from bit 31. The result therefore lies between 1 and 31, or is 32.
- R4: When no bit matches, the result is 32. This covers an all-zero word in find-one, an all-ones word in find-zero, and a word whose bits are all equal in find-change.
- R5: `resultValid` is high for exactly one cycle, the cycle right after a search write. In that cycle the new result is readable.
- R6: With `busAddr` equal to 3, `busRdata` returns the last searched word. With any other address, `busRdata` returns the result in bits 5:0 and zeros above.
- R7: A write to address 3 is ignored. The result and the stored word keep their values, and no valid pulse follows.
- R8: After reset the result is 32, the stored word is 0, and `resultValid` is low.
- R9: The result and the stored word hold their values through idle cycles until the next search write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrite | input | 1 | Write strobe for the selected address |
| busAddr | input | 2 | Address: 0 find-one, 1 find-zero, 2 find-change, 3 data word |
| busWdata | input | 32 | Word to search |
| busRdata | output | 32 | Read data for `busAddr` (combinational) |
| resultValid | output | 1 | One-cycle pulse after a search write |

## Verification
A search write is taken at the rising edge where `busWrite` is high. Both the result and `resultValid` appear in the cycle that begins at that edge, and in the following cycle `resultValid` must be low again. The driver raises the write at a falling edge. At the next falling edge it lowers the write and points the address at the result. The monitor samples shortly after that falling edge, only while `resultValid` is high, and compares the result with the oldest expected value in the queue. The ignored address-3 writes and the idle holds are checked at later falling edges. These checks read the result and the data word back through the read port.

// File: rtl/bit_seek_pkg.sv
package bit_seek_pkg;

  typedef enum logic [1:0] {
    SEL_ONE    = 2'd0,
    SEL_ZERO   = 2'd1,
    SEL_CHANGE = 2'd2,
    SEL_DATA   = 2'd3
  } selAddr_e;

  typedef struct packed {
    logic     load;
    selAddr_e mode;
  } dpStrobe_t;

endpackage

// File: rtl/bit_seek_ctrl.sv
module bit_seek_ctrl
  import bit_seek_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      busWrite,
  input  logic [1:0] busAddr,
  output dpStrobe_t strobe,
  output logic      resultValid
);

  logic searchWrite;

  assign searchWrite = busWrite && (busAddr != SEL_DATA);

  always_comb begin
    strobe.load = searchWrite;
    strobe.mode = selAddr_e'(busAddr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= searchWrite;
  end

  AST_VALID_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr != 2'd3) |=> resultValid); // R5

  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrite && busAddr != 2'd3) |=> !resultValid); // R7

endmodule

// File: rtl/bit_seek_dp.sv
module bit_seek_dp
  import bit_seek_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int POS_W = $clog2(WIDTH + 1)
)(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dataReg,
  output logic [POS_W-1:0] resultReg
);

  localparam logic [POS_W-1:0] NO_MATCH = POS_W'(WIDTH);

  logic [WIDTH-1:0] matchVec;
  logic [POS_W-1:0] firstPos;
  logic             found;

  always_comb begin
    unique case (strobe.mode)
      SEL_ONE:    matchVec = wdata;
      SEL_ZERO:   matchVec = ~wdata;
      SEL_CHANGE: begin
        matchVec = wdata ^ {WIDTH{wdata[WIDTH-1]}};
        matchVec[WIDTH-1] = 1'b0;
      end
      default:    matchVec = '0;
    endcase
  end

  always_comb begin
    found    = 1'b0;
    firstPos = NO_MATCH;
    for (int i = 0; i < WIDTH; i++) begin
      if (!found && matchVec[WIDTH-1-i]) begin
        firstPos = POS_W'(i);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg   <= '0;
      resultReg <= NO_MATCH;
    end else if (strobe.load) begin
      dataReg   <= wdata;
      resultReg <= firstPos;
    end
  end

  AST_RESULT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    resultReg <= NO_MATCH); // R4

  AST_CHANGE_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.mode == SEL_CHANGE) |=> resultReg != '0); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(resultReg) && $stable(dataReg))); // R9

  AST_ONE_MSB: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.mode == SEL_ONE && wdata[WIDTH-1]) |=> resultReg == '0); // R1

endmodule

// File: rtl/bit_seek.sv
module bit_seek
  import bit_seek_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int POS_W = $clog2(WIDTH + 1)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrite,
  input  logic [1:0]       busAddr,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  output logic             resultValid
);

  dpStrobe_t        strobe;
  logic [WIDTH-1:0] dataReg;
  logic [POS_W-1:0] resultReg;

  bit_seek_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .busWrite    (busWrite),
    .busAddr     (busAddr),
    .strobe      (strobe),
    .resultValid (resultValid)
  );

  bit_seek_dp #(.WIDTH(WIDTH)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wdata     (busWdata),
    .dataReg   (dataReg),
    .resultReg (resultReg)
  );

  always_comb begin
    if (busAddr == SEL_DATA) busRdata = dataReg;
    else                     busRdata = {{(WIDTH-POS_W){1'b0}}, resultReg};
  end

endmodule

// File: tb/tb_bit_seek.sv
module tb_bit_seek;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        resultValid;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int expQ[$];
  string reqQ[$];

  always #4 clk = ~clk;

  bit_seek dut (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .resultValid(resultValid)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int model(input int mode, input logic [31:0] w);
    for (int i = 0; i < 32; i++) begin
      logic b;
      b = w[31-i];
      if (mode == 0 && b) return i;
      if (mode == 1 && !b) return i;
      if (mode == 2 && i > 0 && b != w[31]) return i;
    end
    return 32;
  endfunction

  task automatic search(input int mode, input logic [31:0] w);
    int e;
    e = model(mode, w);
    expQ.push_back(e);
    if (e == 32) reqQ.push_back("R4");
    else if (mode == 0) reqQ.push_back("R1");
    else if (mode == 1) reqQ.push_back("R2");
    else reqQ.push_back("R3");
    @(negedge clk);
    busWrite = 1'b1; busAddr = 2'(mode); busWdata = w;
    @(negedge clk);
    busWrite = 1'b0; busAddr = 2'd0;
    @(negedge clk);
    #1 check(resultValid == 1'b0, "R5 pulse", resultValid, 0);
  endtask

  task automatic readAt(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  always @(negedge clk) begin
    #2;
    if (resultValid) begin
      if (expQ.size() == 0) check(1'b0, "R5 unexpected valid", 1, 0);
      else begin
        int e;
        string r;
        e = expQ.pop_front();
        r = reqQ.pop_front();
        check(busRdata == 32'(e), r, busRdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    #1 check(resultValid == 1'b0, "R8 valid", resultValid, 0);
    check(busRdata == 32, "R8 result", busRdata, 32);
    busAddr = 2'd3;
    #1 check(busRdata == 0, "R8 data", busRdata, 0);
    busAddr = 2'd0;
    @(negedge clk);
    rstN = 1'b1;

    search(0, 32'h8000_0000);
    search(0, 32'h0000_0001);
    search(0, 32'h0001_0000);
    search(0, 32'h0000_0000);
    search(1, 32'hFFFF_FFFF);
    search(1, 32'h7FFF_FFFF);
    search(1, 32'hFFFF_FFFE);
    search(1, 32'hFFF0_FFFF);
    search(2, 32'h0000_0000);
    search(2, 32'hFFFF_FFFF);
    search(2, 32'h4000_0000);
    search(2, 32'hC000_0000);
    search(2, 32'h0000_0001);
    search(2, 32'hFFFF_7FFF);
    search(0, 32'h0123_4567);

    readAt(2'd3, d);
    check(d == 32'h0123_4567, "R6 data readback", d, 32'h0123_4567);
    readAt(2'd1, d);
    check(d == 32'd7, "R6 result via addr1", d, 7);

    @(negedge clk);
    busWrite = 1'b1; busAddr = 2'd3; busWdata = 32'hDEAD_BEEF;
    @(negedge clk);
    busWrite = 1'b0; busAddr = 2'd0;
    #1 check(resultValid == 1'b0, "R7 no valid", resultValid, 0);
    check(busRdata == 32'd7, "R7 result kept", busRdata, 7);
    readAt(2'd3, d);
    check(d == 32'h0123_4567, "R7 data kept", d, 32'h0123_4567);

    repeat (10) @(negedge clk);
    readAt(2'd2, d);
    check(d == 32'd7, "R9 result held", d, 7);
    readAt(2'd3, d);
    check(d == 32'h0123_4567, "R9 data held", d, 32'h0123_4567);

    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R5 missing valid", expQ.size(), 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule